// File: doc/BRIEF.md
# Delayed Transaction Target Controller

This block is the control logic of a bus target that is too slow to finish a transaction within the bus wait-state limits. When a request is first seen, the block records its address, command and byte enables. For writes it also records the write data. It then answers with a retry, so the bus is free again, and runs the recorded request on an internal back-end handshake. The completion status and any read data are stored until the initiator presents the identical request again. That request is then finished in a single data phase.

Only one request is held at a time. Every other request is retried without being recorded, and so is a matching request that arrives while the back end is still working. The stored completion goes to the first initiator that presents a matching request, whoever issued the original. Three distinct stop encodings are used on the bus side:
- retry: claim and stop, no ready;
- delivery: claim, ready and stop, which is a disconnect carrying the one DWORD;
- target abort: stop with claim dropped.

A back-end error becomes a target abort. A stored completion that nobody collects can be dropped by a discard tick.

Top module: `dtc_target`

## Requirements
- R1: While reset is high and in the first cycle after it, rsp_claim, rsp_ready, rsp_stop, rsp_rdata and be_req are all 0.
- R2: Each cycle with req_valid high produces exactly one response in the following cycle, and every response has rsp_stop = 1. With no request, rsp_stop stays 0.
- R3: A request arriving while no entry is held is answered with a retry (claim 1, ready 0, stop 1). From the next cycle be_req is high, with be_addr, be_cmd, be_byten and be_wdata equal to the recorded fields.
- R4: While an entry is held, a request that does not match it is retried and is not recorded. The back end keeps seeing the original fields, and the non-matching request is still retried after completion.
- R5: A matching request that arrives before the back end reports done is retried, and the entry is kept.
- R6: A request matches only if address, command and byte enables are all equal, and, for a write, the write data is equal too. A command is a write when bit 0 of the command is 1. For a read, the write data is ignored.
- R7: A matching request after a successful completion is answered with claim 1, ready 1, stop 1. rsp_rdata carries the stored back-end read data for a read and 0 for a write.
- R8: If the back end reported an error (be_err high with be_done), the matching request is answered with a target abort: claim 0, ready 0, stop 1, rsp_rdata 0.
- R9: After a completion has been delivered, the entry is freed. The same request is then recorded again as new: it gets a retry and a new back-end request.
- R10: A drop_tick while a completion waits frees the entry, so the next matching request is treated as new. A drop_tick while the back end is still working has no effect.
- R11: be_req, once high, stays high with stable request fields until a cycle with be_done high, and falls in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request's first data phase is presented this cycle |
| req_addr | input | 32 | Request address |
| req_cmd | input | 4 | Request command, bit 0 = write |
| req_byten | input | 4 | Request byte enables |
| req_wdata | input | 32 | Request write data |
| drop_tick | input | 1 | Discard pulse for an uncollected completion |
| be_req | output | 1 | Back-end request, held until done |
| be_addr | output | 32 | Recorded address to the back end |
| be_cmd | output | 4 | Recorded command to the back end |
| be_byten | output | 4 | Recorded byte enables to the back end |
| be_wdata | output | 32 | Recorded write data to the back end |
| be_done | input | 1 | Back end finished the request |
| be_err | input | 1 | Back end failed, valid with be_done |
| be_rdata | input | 32 | Back-end read data, valid with be_done |
| rsp_claim | output | 1 | Response: target claims the transaction |
| rsp_ready | output | 1 | Response: data transferred |
| rsp_stop | output | 1 | Response: stop asserted |
| rsp_rdata | output | 32 | Response read data |

## Verification
Some properties are checked by assertions on every cycle:
- each request yields a response one cycle later, and no response appears without a request;
- a response asserting ready also claims and stops, and an abort carries neither ready nor data;
- the back-end request holds with stable fields until done, and rises only after a request.

Other behaviours need the bench's scenarios:
- which request is recorded and how matching depends on each field, including write data being ignored for reads;
- that competing requests are not recorded;
- that an entry is freed after delivery or discard, and that a discard during execution has no effect.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int CMD_W  = 4;
    parameter int BEN_W  = DATA_W / 8;
    parameter int WR_BIT = 0;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
        logic [BEN_W-1:0]  ben;
        logic [DATA_W-1:0] wdata;
    } req_t;

    typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_DONE} slot_e;
    typedef enum logic [1:0] {ACT_NONE, ACT_RETRY, ACT_GIVE, ACT_ABORT} act_e;

    typedef struct packed {
        logic claim;
        logic ready;
        logic stop;
    } rsp_t;

    function automatic logic is_write(input logic [CMD_W-1:0] c);
        return c[WR_BIT];
    endfunction

    function automatic rsp_t encode(input act_e a);
        case (a)
            ACT_RETRY: return '{claim: 1'b1, ready: 1'b0, stop: 1'b1};
            ACT_GIVE:  return '{claim: 1'b1, ready: 1'b1, stop: 1'b1};
            ACT_ABORT: return '{claim: 1'b0, ready: 1'b0, stop: 1'b1};
            default:   return '{claim: 1'b0, ready: 1'b0, stop: 1'b0};
        endcase
    endfunction
endpackage

// File: rtl/dtc_match.sv
module dtc_match
    import dtc_pkg::*;
(
    input  req_t held,
    input  req_t incoming,
    output logic hit
);
    logic hdr_eq;
    logic dat_eq;

    always_comb begin
        hdr_eq = (held.addr == incoming.addr) && (held.cmd == incoming.cmd)
              && (held.ben == incoming.ben);
        dat_eq = !is_write(held.cmd) || (held.wdata == incoming.wdata);
        hit    = hdr_eq && dat_eq;
    end
endmodule

// File: rtl/dtc_slot.sv
module dtc_slot
    import dtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  req_t              req,
    input  logic              hit,
    input  logic              drop_tick,
    input  logic              be_done,
    input  logic              be_err,
    input  logic [DATA_W-1:0] be_rdata,
    output slot_e             state,
    output req_t              entry,
    output act_e              act,
    output logic [DATA_W-1:0] give_data
);
    logic              sts_err;
    logic [DATA_W-1:0] sts_data;

    always_comb begin
        act = ACT_NONE;
        if (req_valid) begin
            if (state == ST_DONE && hit)
                act = sts_err ? ACT_ABORT : ACT_GIVE;
            else
                act = ACT_RETRY;
        end
        give_data = (act == ACT_GIVE && !is_write(entry.cmd)) ? sts_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            entry    <= '0;
            sts_err  <= 1'b0;
            sts_data <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    entry <= req;
                    state <= ST_EXEC;
                end
                ST_EXEC: if (be_done) begin
                    sts_err  <= be_err;
                    sts_data <= be_rdata;
                    state    <= ST_DONE;
                end
                ST_DONE: if (act == ACT_GIVE || act == ACT_ABORT || drop_tick)
                    state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dtc_resp.sv
module dtc_resp
    import dtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  act_e              act,
    input  logic [DATA_W-1:0] give_data,
    output rsp_t              rsp,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp   <= '0;
            rdata <= '0;
        end else begin
            rsp   <= encode(act);
            rdata <= give_data;
        end
    end

    // R7
    ready_needs_claim_chk: assert property (@(posedge clk) disable iff (rst)
        rsp.ready |-> (rsp.claim && rsp.stop));
    // R8
    abort_no_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp.stop && !rsp.claim) |-> (!rsp.ready && rdata == '0));
endmodule

// File: rtl/dtc_target.sv
module dtc_target
    import dtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [BEN_W-1:0]  req_byten,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              drop_tick,
    output logic              be_req,
    output logic [ADDR_W-1:0] be_addr,
    output logic [CMD_W-1:0]  be_cmd,
    output logic [BEN_W-1:0]  be_byten,
    output logic [DATA_W-1:0] be_wdata,
    input  logic              be_done,
    input  logic              be_err,
    input  logic [DATA_W-1:0] be_rdata,
    output logic              rsp_claim,
    output logic              rsp_ready,
    output logic              rsp_stop,
    output logic [DATA_W-1:0] rsp_rdata
);
    req_t              cur_req;
    req_t              entry;
    slot_e             state;
    act_e              act;
    logic              hit;
    logic [DATA_W-1:0] give_data;
    rsp_t              rsp;

    assign cur_req = '{addr: req_addr, cmd: req_cmd, ben: req_byten, wdata: req_wdata};

    dtc_match u_match (.held(entry), .incoming(cur_req), .hit(hit));

    dtc_slot u_slot (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req(cur_req), .hit(hit),
        .drop_tick(drop_tick), .be_done(be_done), .be_err(be_err), .be_rdata(be_rdata),
        .state(state), .entry(entry), .act(act), .give_data(give_data)
    );

    dtc_resp u_resp (
        .clk(clk), .rst(rst), .act(act), .give_data(give_data),
        .rsp(rsp), .rdata(rsp_rdata)
    );

    assign be_req    = (state == ST_EXEC);
    assign be_addr   = entry.addr;
    assign be_cmd    = entry.cmd;
    assign be_byten  = entry.ben;
    assign be_wdata  = entry.wdata;
    assign rsp_claim = rsp.claim;
    assign rsp_ready = rsp.ready;
    assign rsp_stop  = rsp.stop;

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_stop);
    // R2
    no_resp_unasked_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_stop);
    // R3
    be_start_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(be_req) |-> $past(req_valid));
    // R11
    be_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (be_req && !be_done) |=> (be_req && $stable(be_addr) && $stable(be_cmd)
                                  && $stable(be_byten) && $stable(be_wdata)));
    // R11
    be_release_chk: assert property (@(posedge clk) disable iff (rst)
        (be_req && be_done) |=> !be_req);
endmodule

// File: tb/sim_dtc_target.sv
module sim_dtc_target;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] RD = 4'h6;
    localparam logic [3:0] WR = 4'h7;
    localparam logic [34:0] RETRY = {3'b101, 32'h0};
    localparam logic [34:0] ABORT = {3'b001, 32'h0};

    logic clk = 0, rst = 1;
    logic req_valid = 0, drop_tick = 0, be_done = 0, be_err = 0;
    logic [31:0] req_addr = 0, req_wdata = 0, be_rdata = 0;
    logic [3:0] req_cmd = 0, req_byten = 0;
    logic be_req, rsp_claim, rsp_ready, rsp_stop;
    logic [31:0] be_addr, be_wdata, rsp_rdata;
    logic [3:0] be_cmd, be_byten;

    int n_chk = 0, n_bad = 0;
    logic [34:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dtc_target u0 (.*);

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] a, input logic [3:0] c, input logic [3:0] b,
                        input logic [31:0] w, input logic [34:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_cmd = c; req_byten = b; req_wdata = w;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic finish_be(input logic err, input logic [31:0] d);
        @(negedge clk);
        be_done = 1; be_err = err; be_rdata = d;
        @(negedge clk);
        be_done = 0; be_err = 0; be_rdata = 0;
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && (rsp_stop || rsp_claim || rsp_ready)) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected response", {29'h0, rsp_claim, rsp_ready, rsp_stop, rsp_rdata}, 64'h0);
            end else begin
                logic [34:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({rsp_claim, rsp_ready, rsp_stop, rsp_rdata} == e, t,
                    {29'h0, rsp_claim, rsp_ready, rsp_stop, rsp_rdata}, {29'h0, e});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({rsp_claim, rsp_ready, rsp_stop, rsp_rdata, be_req} == 0, "R1 reset outputs",
            {rsp_claim, rsp_ready, rsp_stop, rsp_rdata, be_req}, 0);
        rst = 0;
        @(negedge clk);
        chk({rsp_stop, be_req} == 0, "R1 after reset", {rsp_stop, be_req}, 0);

        // read A: recorded, retried, back end started
        send(32'h1000, RD, 4'hF, 32'h0, RETRY, "R3 first request retried");
        chk(be_req && be_addr == 32'h1000 && be_cmd == RD && be_byten == 4'hF,
            "R3 back end fields", {be_req, be_addr, be_cmd, be_byten}, {1'b1, 32'h1000, RD, 4'hF});
        send(32'h2000, WR, 4'h3, 32'h55, RETRY, "R4 other request retried");
        chk(be_addr == 32'h2000 ? 1'b0 : 1'b1, "R4 other not recorded", be_addr, 32'h1000);
        send(32'h1000, RD, 4'hF, 32'h0, RETRY, "R5 match while busy retried");
        drop_tick = 1; @(negedge clk); drop_tick = 0;
        repeat (3) @(negedge clk);
        chk(be_req && be_addr == 32'h1000, "R11 R10 back end held", {be_req, be_addr}, {1'b1, 32'h1000});
        finish_be(0, 32'hCAFE_0001);
        chk(!be_req, "R11 be_req falls after done", be_req, 0);
        send(32'h2000, WR, 4'h3, 32'h55, RETRY, "R4 other still retried at completion");
        send(32'h1000, RD, 4'hE, 32'h0, RETRY, "R6 byte enable mismatch");
        send(32'h1004, RD, 4'hF, 32'h0, RETRY, "R6 address mismatch");
        send(32'h1000, RD, 4'hF, 32'h9999, {3'b111, 32'hCAFE_0001}, "R6 R7 read delivered, wdata ignored");
        @(negedge clk);
        chk(!be_req, "R7 no back end after delivery", be_req, 0);

        // entry freed: same request is new again, then back-end error
        send(32'h1000, RD, 4'hF, 32'h0, RETRY, "R9 same request now new");
        chk(be_req && be_addr == 32'h1000, "R9 back end restarted", {be_req, be_addr}, {1'b1, 32'h1000});
        finish_be(1, 32'h1234);
        send(32'h1000, RD, 4'hF, 32'h0, ABORT, "R8 error gives target abort");

        // write: data must match
        send(32'h3000, WR, 4'hC, 32'hDEAD_BEEF, RETRY, "R3 write recorded");
        chk(be_req && be_wdata == 32'hDEAD_BEEF && be_cmd == WR, "R3 write fields",
            {be_wdata, be_cmd}, {32'hDEAD_BEEF, WR});
        finish_be(0, 32'h7777);
        send(32'h3000, WR, 4'hC, 32'hDEAD_BEEE, RETRY, "R6 write data mismatch");
        send(32'h3000, RD, 4'hC, 32'hDEAD_BEEF, RETRY, "R6 command mismatch");
        send(32'h3000, WR, 4'hC, 32'hDEAD_BEEF, {3'b111, 32'h0}, "R7 write delivered no data");

        // discard of a waiting completion
        send(32'h4000, RD, 4'h1, 32'h0, RETRY, "R10 request recorded");
        finish_be(0, 32'hABCD);
        drop_tick = 1; @(negedge clk); drop_tick = 0;
        send(32'h4000, RD, 4'h1, 32'h0, RETRY, "R10 dropped entry retried as new");
        chk(be_req, "R10 back end restarted after drop", be_req, 1);
        finish_be(0, 32'h5A5A);
        send(32'h4000, RD, 4'h1, 32'h0, {3'b111, 32'h5A5A}, "R7 new data delivered");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
        report();
    end
endmodule